// File: doc/BRIEF.md
# Layer priority pixel compositor

The compositor takes, for each screen column, one candidate pixel from each of five layers (four background planes and one sprite plane) and emits the single 15-bit colour that ends up on screen. Each candidate has a present flag, a 15-bit colour and a 2-bit depth value. The smallest depth value is the frontmost. When two present layers have the same depth, a fixed ranking breaks the tie: the sprite plane comes first, then background planes 0, 1, 2 and 3. If no layer is present in a column, the backdrop colour is shown with its top bit dropped.

The block handles one column per clock. A pixel is offered through `pix_en`. It is accepted only when the current row is one of the visible rows. Its result appears on the registered outputs one clock later, with a strobe and the column index. The column index runs from 0 to 239 over the accepted pixels and then wraps. Strobes offered on rows outside the visible range are dropped, and they do not move the column index.

Top module: `lpc_compositor`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `px_valid` is 0, `px_x` is 0 and `px_color` is 0.
- R2: Among the present layers, the one with the numerically smallest depth value provides the output colour. Depth 0 is in front of 1, 1 is in front of 2, and 2 is in front of 3.
- R3: When present layers share the smallest depth, the winner is taken in this fixed order: sprite, background 0, background 1, background 2, background 3.
- R4: A layer whose present flag is 0 never provides the output colour, whatever its depth or colour.
- R5: When no layer is present, the output is bits 14:0 of `backdrop`. Bit 15 of `backdrop` has no effect on the output.
- R6: A pixel accepted at a rising clock edge is shown on `px_color` and `px_x` after that same edge, with `px_valid` at 1 for exactly that cycle.
- R7: `px_x` gives the index of the accepted pixel. It starts at 0 after reset, rises by one for each accepted pixel, and goes from 239 back to 0.
- R8: A strobe offered while `row` is 160 or greater is not accepted. `px_valid` stays at 0, `px_color` and `px_x` keep their values, and the column index does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Offers one column's layer records this cycle |
| row | input | 8 | Current line number |
| bg_valid | input | 4 | Present flag per background plane (bit n = plane n) |
| bg_color | input | 60 | Background colours, plane n in bits 15n+14:15n |
| bg_prio | input | 8 | Background depths, plane n in bits 2n+1:2n |
| obj_valid | input | 1 | Sprite plane present flag |
| obj_color | input | 15 | Sprite plane colour |
| obj_prio | input | 2 | Sprite plane depth |
| backdrop | input | 16 | Backdrop palette entry; bit 15 ignored |
| px_valid | output | 1 | One-cycle strobe for a composited pixel |
| px_x | output | 8 | Column index of the composited pixel |
| px_color | output | 15 | Composited colour |

## Verification
The bench tries every combination of the five present flags with every combination of the five depths, which is 32768 columns. Each column gets its expected winner from a plain front-to-back scan, so the bench finds any design that reverses the depth order, that lets a background beat the sprite plane on a tie, or that lets an absent layer win. In many of these columns the backdrop has bit 15 set, so a design that does not drop that bit shows the wrong colour in every empty column. The bench follows the column index through several wraps at 239. It also sends strobes on rows 160 and above and then checks that the next visible pixel carries on with the count that was interrupted. A design that advances the index or updates the colour on a hidden row fails that check.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam int unsigned LPC_NUM_BG    = 4;
  localparam int unsigned LPC_COLOR_W   = 15;
  localparam int unsigned LPC_PRIO_W    = 2;
  localparam int unsigned LPC_LINE_W    = 240;
  localparam int unsigned LPC_VIS_LINES = 160;
  localparam int unsigned LPC_ROW_W     = 8;
endpackage

// File: rtl/lpc_rank.sv
// Builds one ordering key per layer: {absent, depth, layer index}.
// A smaller key is nearer to the viewer, so the index settles ties.
module lpc_rank #(
  parameter int unsigned NUM_LAYERS = 5,
  parameter int unsigned PRIO_W     = 2,
  parameter int unsigned IDX_W      = 3,
  parameter int unsigned KEY_W      = 1 + PRIO_W + IDX_W
) (
  input  logic [NUM_LAYERS-1:0]        lay_valid,
  input  logic [NUM_LAYERS*PRIO_W-1:0] lay_prio,
  output logic [NUM_LAYERS*KEY_W-1:0]  lay_key
);
  for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_key
    assign lay_key[i*KEY_W +: KEY_W] =
      {~lay_valid[i], lay_prio[i*PRIO_W +: PRIO_W], IDX_W'(i)};
  end
endmodule

// File: rtl/lpc_min_select.sv
// Linear minimum search over the layer keys.
module lpc_min_select #(
  parameter int unsigned NUM_LAYERS = 5,
  parameter int unsigned IDX_W      = 3,
  parameter int unsigned KEY_W      = 6
) (
  input  logic [NUM_LAYERS*KEY_W-1:0] lay_key,
  output logic [IDX_W-1:0]            win_idx,
  output logic                        win_hit
);
  logic [KEY_W-1:0] best [NUM_LAYERS];

  assign best[0] = lay_key[0 +: KEY_W];
  for (genvar i = 1; i < NUM_LAYERS; i++) begin : g_chain
    assign best[i] = (lay_key[i*KEY_W +: KEY_W] < best[i-1]) ?
                     lay_key[i*KEY_W +: KEY_W] : best[i-1];
  end

  assign win_hit = ~best[NUM_LAYERS-1][KEY_W-1];
  assign win_idx = best[NUM_LAYERS-1][IDX_W-1:0];
endmodule

// File: rtl/lpc_col_counter.sv
// Column index of the next accepted pixel; wraps at the line width.
module lpc_col_counter #(
  parameter int unsigned LINE_W = 240,
  parameter int unsigned X_W    = $clog2(LINE_W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  output logic [X_W-1:0] x_cur
);
  localparam logic [X_W-1:0] X_LAST = X_W'(LINE_W - 1);

  logic [X_W-1:0] x_q, x_d;

  always_comb begin
    x_d = x_q;
    if (adv) begin
      x_d = (x_q == X_LAST) ? '0 : x_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) x_q <= '0;
    else        x_q <= x_d;
  end

  assign x_cur = x_q;

  a_r7_x_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    x_q <= X_LAST);
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && x_q == X_LAST) |=> (x_q == '0));
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(x_q));
endmodule

// File: rtl/lpc_compositor.sv
module lpc_compositor
  import lpc_pkg::*;
#(
  parameter int unsigned NUM_BG    = LPC_NUM_BG,
  parameter int unsigned COLOR_W   = LPC_COLOR_W,
  parameter int unsigned PRIO_W    = LPC_PRIO_W,
  parameter int unsigned LINE_W    = LPC_LINE_W,
  parameter int unsigned VIS_LINES = LPC_VIS_LINES,
  parameter int unsigned ROW_W     = LPC_ROW_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pix_en,
  input  logic [ROW_W-1:0]          row,
  input  logic [NUM_BG-1:0]         bg_valid,
  input  logic [NUM_BG*COLOR_W-1:0] bg_color,
  input  logic [NUM_BG*PRIO_W-1:0]  bg_prio,
  input  logic                      obj_valid,
  input  logic [COLOR_W-1:0]        obj_color,
  input  logic [PRIO_W-1:0]         obj_prio,
  input  logic [COLOR_W:0]          backdrop,
  output logic                      px_valid,
  output logic [$clog2(LINE_W)-1:0] px_x,
  output logic [COLOR_W-1:0]        px_color
);
  localparam int unsigned NUM_LAYERS = NUM_BG + 1;
  localparam int unsigned IDX_W      = $clog2(NUM_LAYERS);
  localparam int unsigned KEY_W      = 1 + PRIO_W + IDX_W;
  localparam int unsigned X_W        = $clog2(LINE_W);

  // Layer 0 is the sprite plane, so it wins ties; backgrounds follow.
  logic [NUM_LAYERS-1:0]         lay_valid;
  logic [NUM_LAYERS*PRIO_W-1:0]  lay_prio;
  logic [NUM_LAYERS*COLOR_W-1:0] lay_color;
  logic [NUM_LAYERS*KEY_W-1:0]   lay_key;
  logic [IDX_W-1:0]              win_idx;
  logic                          win_hit;
  logic                          accept;
  logic [X_W-1:0]                x_cur;
  logic [COLOR_W-1:0]            sel_color;
  logic                          unused_backdrop_msb;

  assign lay_valid = {bg_valid, obj_valid};
  assign lay_prio  = {bg_prio, obj_prio};
  assign lay_color = {bg_color, obj_color};
  assign unused_backdrop_msb = backdrop[COLOR_W];

  assign accept = pix_en && (row < ROW_W'(VIS_LINES));

  lpc_rank #(
    .NUM_LAYERS (NUM_LAYERS),
    .PRIO_W     (PRIO_W),
    .IDX_W      (IDX_W),
    .KEY_W      (KEY_W)
  ) u_rank (
    .lay_valid (lay_valid),
    .lay_prio  (lay_prio),
    .lay_key   (lay_key)
  );

  lpc_min_select #(
    .NUM_LAYERS (NUM_LAYERS),
    .IDX_W      (IDX_W),
    .KEY_W      (KEY_W)
  ) u_select (
    .lay_key (lay_key),
    .win_idx (win_idx),
    .win_hit (win_hit)
  );

  lpc_col_counter #(
    .LINE_W (LINE_W),
    .X_W    (X_W)
  ) u_col (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (accept),
    .x_cur (x_cur)
  );

  // Colour mux; the backdrop loses its top bit.
  always_comb begin
    sel_color = backdrop[COLOR_W-1:0];
    for (int i = 0; i < NUM_LAYERS; i++) begin
      if (win_hit && win_idx == IDX_W'(i)) begin
        sel_color = lay_color[i*COLOR_W +: COLOR_W];
      end
    end
  end

  // Output stage: next-state, then register.
  logic               vld_q, vld_d;
  logic [X_W-1:0]     x_q, x_d;
  logic [COLOR_W-1:0] col_q, col_d;

  always_comb begin
    vld_d = accept;
    x_d   = x_q;
    col_d = col_q;
    if (accept) begin
      x_d   = x_cur;
      col_d = sel_color;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      x_q   <= '0;
      col_q <= '0;
    end else begin
      vld_q <= vld_d;
      x_q   <= x_d;
      col_q <= col_d;
    end
  end

  assign px_valid = vld_q;
  assign px_x     = x_q;
  assign px_color = col_q;

  a_r4_winner_present: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> lay_valid[win_idx]);
  a_r5_none_present: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> (lay_valid == '0));
  a_r5_backdrop_out: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lay_valid == '0) |=> (px_color == $past(backdrop[COLOR_W-1:0])));
  a_r6_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> px_valid);
  a_r8_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !px_valid);
  a_r8_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(px_color) && $stable(px_x)));
  a_r3_sprite_tie: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && obj_valid && obj_prio == '0) |=> (px_color == $past(obj_color)));
endmodule

// File: tb/lpc_compositor_bench.sv
module lpc_compositor_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_en;
  logic [7:0]  row;
  logic [3:0]  bg_valid;
  logic [59:0] bg_color;
  logic [7:0]  bg_prio;
  logic        obj_valid;
  logic [14:0] obj_color;
  logic [1:0]  obj_prio;
  logic [15:0] backdrop;
  logic        px_valid;
  logic [7:0]  px_x;
  logic [14:0] px_color;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lpc_compositor u_lpc_compositor (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .row(row),
    .bg_valid(bg_valid), .bg_color(bg_color), .bg_prio(bg_prio),
    .obj_valid(obj_valid), .obj_color(obj_color), .obj_prio(obj_prio),
    .backdrop(backdrop), .px_valid(px_valid), .px_x(px_x), .px_color(px_color)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      if (n_fail < 20)
        $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Layer L (0 = sprite, 1..4 = bg0..3) data for a given depth pattern.
  function automatic logic [14:0] lay_col(input int l, input int pr, input int v);
    return 15'((l + 1) * 4096 + ((pr * 7 + v) & 12'hfff));
  endfunction

  // Front-to-back scan: depth 0..3, then sprite, bg0..bg3.
  function automatic logic [14:0] expect_col(input int v, input int pr, input logic [15:0] bd);
    for (int p = 0; p < 4; p++)
      for (int l = 0; l < 5; l++)
        if (v[l] && ((pr >> (2 * l)) & 3) == p) return lay_col(l, pr, v);
    return bd[14:0];
  endfunction

  task automatic apply(input int v, input int pr, input logic [15:0] bd);
    obj_valid = v[0];
    obj_prio  = 2'(pr);
    obj_color = lay_col(0, pr, v);
    for (int b = 0; b < 4; b++) begin
      bg_valid[b]        = v[b + 1];
      bg_prio[2*b +: 2]  = 2'(pr >> (2 * (b + 1)));
      bg_color[15*b +: 15] = lay_col(b + 1, pr, v);
    end
    backdrop = bd;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int ex;
    logic [14:0] last_col;
    logic [15:0] bd;
    rst_n = 1'b0; pix_en = 1'b0; row = '0;
    apply(0, 0, 16'h0);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid in reset", 32'(px_valid), 0);
    chk("R1 x in reset", 32'(px_x), 0);
    chk("R1 color in reset", 32'(px_color), 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk) #1;
    chk("R1 valid after release", 32'(px_valid), 0);
    chk("R1 color after release", 32'(px_color), 0);

    // R2 R3 R4 R5 R6 R7: full sweep of flags and depths.
    ex = 0;
    for (int v = 0; v < 32; v++) begin
      for (int pr = 0; pr < 1024; pr++) begin
        bd = 16'((pr[0] ? 16'h8000 : 16'h0) | 16'((v * 997 + pr) & 16'h7fff));
        @(negedge clk);
        pix_en = 1'b1;
        row = 8'((v * 5 + pr) % 160);
        apply(v, pr, bd);
        @(posedge clk) #1;
        chk("R2 R3 R4 R5 colour", 32'(px_color), 32'(expect_col(v, pr, bd)));
        chk("R6 strobe", 32'(px_valid), 1);
        chk("R7 column index", 32'(px_x), 32'(ex));
        ex = (ex == 239) ? 0 : ex + 1;
      end
    end

    // R5: backdrop with bit 15 set and nothing present.
    @(negedge clk) apply(0, 0, 16'hffff); row = 8'd10;
    @(posedge clk) #1;
    chk("R5 backdrop msb dropped", 32'(px_color), 32'h7fff);
    ex = (ex == 239) ? 0 : ex + 1;
    last_col = px_color;

    // R8: hidden rows are ignored.
    for (int r = 160; r < 164; r++) begin
      @(negedge clk) row = 8'(r); apply(1, 0, 16'h0123);
      @(posedge clk) #1;
      chk("R8 no strobe on hidden row", 32'(px_valid), 0);
      chk("R8 colour held", 32'(px_color), 32'(last_col));
    end
    @(negedge clk) row = 8'd227;
    @(posedge clk) #1;
    chk("R8 no strobe on last row", 32'(px_valid), 0);
    @(negedge clk) pix_en = 1'b0; row = 8'd5;
    @(posedge clk) #1;
    chk("R6 idle gives no strobe", 32'(px_valid), 0);
    @(negedge clk) pix_en = 1'b1; row = 8'd159; apply(1, 3, 16'h0);
    @(posedge clk) #1;
    chk("R8 index resumes", 32'(px_x), 32'(ex));
    chk("R6 last visible row accepted", 32'(px_valid), 1);
    chk("R2 single sprite", 32'(px_color), 32'(lay_col(0, 3, 1)));
    @(negedge clk) pix_en = 1'b0;
    @(posedge clk) #1;
    chk("R6 strobe lasts one cycle", 32'(px_valid), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule